// File: doc/BRIEF.md
# Receive Cell Path Arbiter

This block feeds a 4-bit receive data path from two cell sources. The first source is a PHY that delivers 53-byte ATM cells over an 8-bit UTOPIA Level 1 receive port. The block uses the cell-level handshake on that port: it polls the PHY's cell-available flag and, once it commits, pulls a whole cell. The second source is a local generator of status or reply cells. It raises a request and then waits for a grant.

UTOPIA cells are stored whole in a small cell buffer. Between cells the block decides what goes out next. A buffered UTOPIA cell always wins. The local source is admitted only when no UTOPIA cell is stored, being pulled or being offered. The chosen cell leaves as 106 nibbles, each byte as its high nibble and then its low nibble, with a start-of-cell strobe on the first nibble.

The block has one clock, the nibble clock. A byte strobe marks every second cycle and stands for the UTOPIA byte clock at half the rate. The output therefore runs at twice the input byte rate.

Top module: `rx_cell_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `nib_valid`, `nib_soc`, `utp_rd_en`, `loc_gnt` and `byte_stb` are all 0 after that edge.
- R2: `byte_stb` is high on every second cycle. A UTOPIA byte is taken only at a clock edge where both `byte_stb` and `utp_rd_en` are high. `utp_rd_en` changes only at such byte-strobe edges.
- R3: `utp_rd_en` rises only after a byte-strobe edge at which `utp_clav` was high and a buffer slot was free. Once high, it stays high until a full cell of 53 bytes has been taken. It then stays low for at least one byte-strobe edge.
- R4: A byte taken with `utp_soc` high is stored as byte 0 of the current cell and restarts the byte count. Bytes taken before it in the same pull are discarded.
- R5: Every output cell is 106 consecutive cycles with `nib_valid` high. Byte k of the cell is nibbles 2k and 2k+1, with bits 7:4 first and bits 3:0 second.
- R6: `nib_soc` is high with the first nibble of a cell and low for every other nibble.
- R7: UTOPIA cells leave whole and in arrival order. No two cells are ever interleaved.
- R8: `loc_gnt` rises only from an idle decision cycle in which no cell was buffered, no UTOPIA pull was in progress and `utp_clav` was low. A UTOPIA cell that is pending therefore goes out before a waiting local cell.
- R9: `loc_gnt` stays high for exactly 106 cycles per grant. During the grant, `loc_idx` gives the byte index the local source must present on `loc_data` in the same cycle. Those bytes form the output cell.
- R10: While every buffer slot holds a stored cell, `utp_rd_en` stays low, so no byte is ever lost.
- R11: `nib_valid` is low for at least one cycle between any two output cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock; all logic on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_stb | output | 1 | High every second cycle; marks the UTOPIA byte clock edge |
| utp_clav | input | 1 | PHY has at least one whole cell available |
| utp_rd_en | output | 1 | Pull enable to the PHY; the PHY presents a byte for each strobe edge while high |
| utp_data | input | 8 | UTOPIA receive byte |
| utp_soc | input | 1 | Marks byte 0 of a cell on the UTOPIA port |
| loc_req | input | 1 | Local cell source wants to send one cell |
| loc_gnt | output | 1 | Local cell is being sent; held for the whole cell |
| loc_idx | output | 6 | Byte index the local source must present during the grant |
| loc_data | input | 8 | Local cell byte at `loc_idx` |
| nib_data | output | 4 | Output nibble |
| nib_soc | output | 1 | First nibble of a cell |
| nib_valid | output | 1 | `nib_data` carries a cell nibble |

## Verification
The cell path is tried with several patterns, each of which separates correct behaviour from a different fault. A lone UTOPIA cell confirms that nibbles are ordered correctly within each byte and that the strobe is placed on the right nibble. A lone local cell exercises the grant and the `loc_idx` lookup. A local request raised while a UTOPIA cell is still on offer only passes if the UTOPIA cell comes out first. A pull that begins with unmarked junk bytes before the marked byte 0 shows whether the block realigns on the start-of-cell marker. A local cell followed by three queued UTOPIA cells, with a single buffer slot, shows whether the pull enable is held off while the slot is occupied, with all cells still intact and in order.

// File: rtl/rxa_pkg.sv
// Package: shared types of the receive cell path arbiter.
// Assumes: nothing; types only.
package rxa_pkg;

    // State of the nibble transmitter.
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // Source of the cell being transmitted.
    typedef enum logic {
        SRC_BUF = 1'b0,
        SRC_LOC = 1'b1
    } cell_src_e;

endpackage

// File: rtl/rxa_utp_fill.sv
// Module: rxa_utp_fill
// Generates the half-rate byte strobe and runs the UTOPIA receive cell-level
// handshake. It writes each taken byte into the current buffer slot and
// reports when a complete cell has been stored.
// Assumes: the PHY presents one byte for every strobe edge while rd_en is
// high, and it only raises clav when it holds a whole cell.
module rxa_utp_fill #(
    parameter int CELL_BYTES = 53,
    localparam int IW = $clog2(CELL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          utp_clav,
    input  logic [7:0]    utp_data,
    input  logic          utp_soc,
    input  logic          slot_free,
    output logic          byte_stb,
    output logic          rd_en,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_byte,
    output logic          commit
);

    localparam logic [IW-1:0] LAST_IDX = IW'(CELL_BYTES - 1);

    logic          phase;
    logic [IW-1:0] wr_cnt;

    // Toggle the byte phase each cycle; a high phase marks a byte edge.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    assign byte_stb = phase;

    // Store position: a marked byte always lands at index 0.
    assign wr_idx  = utp_soc ? '0 : wr_cnt;
    assign wr_byte = utp_data;
    assign wr_en   = phase & rd_en;
    assign commit  = wr_en && (wr_idx == LAST_IDX);

    // Handshake: start a pull on clav with room, stop after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en  <= 1'b0;
            wr_cnt <= '0;
        end else if (phase) begin
            if (rd_en) begin
                if (wr_idx == LAST_IDX) begin
                    rd_en  <= 1'b0;
                    wr_cnt <= '0;
                end else begin
                    wr_cnt <= wr_idx + 1'b1;
                end
            end else if (utp_clav && slot_free) begin
                rd_en  <= 1'b1;
                wr_cnt <= '0;
            end
        end
    end

    // R2: the pull enable only moves on byte-strobe edges.
    a_r2_rd_en_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> $stable(rd_en));

    // R3: a pull only starts after clav with a free slot.
    a_r3_start_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> $past(utp_clav && slot_free));

    // R10: no pull may start while the buffer has no free slot.
    a_r10_no_pull_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !rd_en && !slot_free) |=> !rd_en);

endmodule

// File: rtl/rxa_cell_store.sv
// Module: rxa_cell_store
// Holds CELL_SLOTS whole cells in a flat byte memory that is used as a ring
// of slots. It tracks how many slots hold a complete cell and serves byte
// reads from the oldest slot.
// Assumes: commit is never raised while every slot is full, and release
// is never raised while no slot is full.
module rxa_cell_store #(
    parameter int CELL_BYTES = 53,
    parameter int CELL_SLOTS = 2,
    localparam int IW    = $clog2(CELL_BYTES),
    localparam int DEPTH = CELL_BYTES * CELL_SLOTS,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = (CELL_SLOTS > 1) ? $clog2(CELL_SLOTS) : 1,
    localparam int CW    = $clog2(CELL_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic          commit,
    input  logic          release_cell,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic          cell_ready,
    output logic          slot_free
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(CELL_SLOTS - 1);

    logic [7:0]    mem [DEPTH];
    logic [SW-1:0] wr_slot;
    logic [SW-1:0] rd_slot;
    logic [CW-1:0] full_cnt;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    assign wr_addr = AW'(wr_slot) * AW'(CELL_BYTES) + AW'(wr_idx);
    assign rd_addr = AW'(rd_slot) * AW'(CELL_BYTES) + AW'(rd_idx);

    // Byte write into the slot being filled.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_byte;
    end

    assign rd_byte = mem[rd_addr];

    // Advance the fill and drain slot pointers around the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
            rd_slot <= '0;
        end else begin
            if (commit)
                wr_slot <= (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
            if (release_cell)
                rd_slot <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
        end
    end

    // Count slots holding a complete cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_cnt <= '0;
        end else begin
            unique case ({commit, release_cell})
                2'b10:   full_cnt <= full_cnt + 1'b1;
                2'b01:   full_cnt <= full_cnt - 1'b1;
                default: full_cnt <= full_cnt;
            endcase
        end
    end

    assign cell_ready = (full_cnt != '0);
    assign slot_free  = (full_cnt < CW'(CELL_SLOTS));

    // R10: a cell is only completed into a slot that was free.
    a_r10_commit_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> full_cnt < CW'(CELL_SLOTS));

    // R7: a cell is only released if one is stored.
    a_r7_release_has_cell: assert property (@(posedge clk) disable iff (!rst_n)
        release_cell |-> full_cnt != '0);

endmodule

// File: rtl/rxa_nib_tx.sv
// Module: rxa_nib_tx
// Picks the next cell source at each idle decision cycle and sends the cell
// as 2*CELL_BYTES nibbles, the high nibble of each byte first, with a
// start-of-cell strobe on nibble 0.
// Assumes: the selected source presents the byte at byte_idx combinationally
// in the same cycle.
module rxa_nib_tx
    import rxa_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    localparam int IW = $clog2(CELL_BYTES),
    localparam int NW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cell_ready,
    input  logic          filling,
    input  logic          utp_clav,
    input  logic          loc_req,
    input  logic [7:0]    buf_byte,
    input  logic [7:0]    loc_data,
    output logic [IW-1:0] byte_idx,
    output logic          loc_gnt,
    output logic          release_cell,
    output logic [3:0]    nib_data,
    output logic          nib_soc,
    output logic          nib_valid
);

    localparam logic [NW-1:0] LAST_NIB = NW'(2 * CELL_BYTES - 1);
    localparam int            NIBS     = 2 * CELL_BYTES;

    tx_state_e     state;
    cell_src_e     src;
    logic [NW-1:0] nib_cnt;
    logic [7:0]    cur_byte;
    logic [3:0]    cur_nib;

    assign byte_idx     = nib_cnt[NW-1:1];
    assign cur_byte     = (src == SRC_LOC) ? loc_data : buf_byte;
    assign cur_nib      = nib_cnt[0] ? cur_byte[3:0] : cur_byte[7:4];
    assign loc_gnt      = (state == TX_SEND) && (src == SRC_LOC);
    assign release_cell = (state == TX_SEND) && (src == SRC_BUF) && (nib_cnt == LAST_NIB);

    // Arbitrate at idle, then step through the cell one nibble per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            src     <= SRC_BUF;
            nib_cnt <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    nib_cnt <= '0;
                    if (cell_ready) begin
                        state <= TX_SEND;
                        src   <= SRC_BUF;
                    end else if (loc_req && !filling && !utp_clav) begin
                        state <= TX_SEND;
                        src   <= SRC_LOC;
                    end
                end
                TX_SEND: begin
                    if (nib_cnt == LAST_NIB) begin
                        state   <= TX_IDLE;
                        nib_cnt <= '0;
                    end else begin
                        nib_cnt <= nib_cnt + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Register the output nibble, strobe and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_data  <= '0;
            nib_soc   <= 1'b0;
            nib_valid <= 1'b0;
        end else if (state == TX_SEND) begin
            nib_data  <= cur_nib;
            nib_soc   <= (nib_cnt == '0);
            nib_valid <= 1'b1;
        end else begin
            nib_data  <= '0;
            nib_soc   <= 1'b0;
            nib_valid <= 1'b0;
        end
    end

    // Run-length counters used only by the assertions below.
    logic [NW:0] gnt_len;
    logic [NW:0] val_len;

    // Count consecutive grant cycles and consecutive valid cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_len <= '0;
            val_len <= '0;
        end else begin
            gnt_len <= loc_gnt   ? gnt_len + 1'b1 : '0;
            val_len <= nib_valid ? val_len + 1'b1 : '0;
        end
    end

    // R8: a local grant starts only when nothing from UTOPIA is pending.
    a_r8_local_only_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_gnt) |-> $past(!cell_ready && !filling && !utp_clav));

    // R9: a grant lasts for exactly one whole cell of nibbles.
    a_r9_grant_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loc_gnt) |-> gnt_len == (NW+1)'(NIBS));

    // R5: each valid run carries exactly one whole cell.
    a_r5_valid_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nib_valid) |-> val_len == (NW+1)'(NIBS));

    // R6: the start strobe only comes with a valid nibble.
    a_r6_soc_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        nib_soc |-> nib_valid);

    // R11: a valid run always begins with the start strobe.
    a_r11_run_starts_with_soc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nib_valid) |-> nib_soc);

endmodule

// File: rtl/rx_cell_arbiter.sv
// Module: rx_cell_arbiter
// Top of the receive cell path arbiter. It pulls UTOPIA cells into the cell
// store, arbitrates between stored cells and the local cell source, and
// serialises the winner onto the 4-bit output.
// Assumes: a single nibble clock; the UTOPIA side runs at byte_stb edges.
module rx_cell_arbiter #(
    parameter int CELL_BYTES = 53,
    parameter int CELL_SLOTS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          byte_stb,
    input  logic                          utp_clav,
    output logic                          utp_rd_en,
    input  logic [7:0]                    utp_data,
    input  logic                          utp_soc,
    input  logic                          loc_req,
    output logic                          loc_gnt,
    output logic [$clog2(CELL_BYTES)-1:0] loc_idx,
    input  logic [7:0]                    loc_data,
    output logic [3:0]                    nib_data,
    output logic                          nib_soc,
    output logic                          nib_valid
);

    localparam int IW = $clog2(CELL_BYTES);

    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_byte;
    logic          commit;
    logic          release_cell;
    logic [IW-1:0] byte_idx;
    logic [7:0]    buf_byte;
    logic          cell_ready;
    logic          slot_free;

    rxa_utp_fill #(
        .CELL_BYTES(CELL_BYTES)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .utp_clav (utp_clav),
        .utp_data (utp_data),
        .utp_soc  (utp_soc),
        .slot_free(slot_free),
        .byte_stb (byte_stb),
        .rd_en    (utp_rd_en),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_byte  (wr_byte),
        .commit   (commit)
    );

    rxa_cell_store #(
        .CELL_BYTES(CELL_BYTES),
        .CELL_SLOTS(CELL_SLOTS)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_byte     (wr_byte),
        .commit      (commit),
        .release_cell(release_cell),
        .rd_idx      (byte_idx),
        .rd_byte     (buf_byte),
        .cell_ready  (cell_ready),
        .slot_free   (slot_free)
    );

    rxa_nib_tx #(
        .CELL_BYTES(CELL_BYTES)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cell_ready  (cell_ready),
        .filling     (utp_rd_en),
        .utp_clav    (utp_clav),
        .loc_req     (loc_req),
        .buf_byte    (buf_byte),
        .loc_data    (loc_data),
        .byte_idx    (byte_idx),
        .loc_gnt     (loc_gnt),
        .release_cell(release_cell),
        .nib_data    (nib_data),
        .nib_soc     (nib_soc),
        .nib_valid   (nib_valid)
    );

    assign loc_idx = byte_idx;

    // R1: nothing is offered or pulled right after a reset edge.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!nib_valid && !utp_rd_en && !loc_gnt));

endmodule

// File: tb/tb_rx_cell_arbiter.sv
`timescale 1ns/1ps
module tb_rx_cell_arbiter;

    localparam int CB   = 53;
    localparam int NIBS = 2 * CB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_stb;
    logic       utp_clav = 1'b0;
    logic       utp_rd_en;
    logic [7:0] utp_data = '0;
    logic       utp_soc = 1'b0;
    logic       loc_req = 1'b0;
    logic       loc_gnt;
    logic [5:0] loc_idx;
    logic [7:0] loc_data;
    logic [3:0] nib_data;
    logic       nib_soc;
    logic       nib_valid;

    always #2.5 clk = ~clk;

    rx_cell_arbiter #(.CELL_BYTES(CB), .CELL_SLOTS(1)) dut (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb),
        .utp_clav(utp_clav), .utp_rd_en(utp_rd_en), .utp_data(utp_data),
        .utp_soc(utp_soc), .loc_req(loc_req), .loc_gnt(loc_gnt),
        .loc_idx(loc_idx), .loc_data(loc_data), .nib_data(nib_data),
        .nib_soc(nib_soc), .nib_valid(nib_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    string cur_req = "R7";

    logic [8:0] phy_q[$];   // {soc, byte} bytes the PHY model still owns
    logic [5:0] exp_q[$];   // {src_local, soc, nibble} expected output
    int         run_q[$];   // expected bytes per pull run
    logic [7:0] loc_cell [CB];

    assign loc_data = loc_cell[loc_idx];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ubyte(input int k, input int i);
        return 8'((k * 37 + i * 5 + 1) & 8'hFF);
    endfunction

    task automatic push_exp(input logic [7:0] b, input bit loc, input bit soc);
        exp_q.push_back({loc, soc, b[7:4]});
        exp_q.push_back({loc, 1'b0, b[3:0]});
    endtask

    // Queue one UTOPIA cell at the PHY model and in the scoreboard.
    task automatic push_utp(input int k);
        for (int i = 0; i < CB; i++) begin
            phy_q.push_back({(i == 0), ubyte(k, i)});
            push_exp(ubyte(k, i), 1'b0, (i == 0));
        end
    endtask

    // Load a local cell, expect it and raise the request.
    task automatic req_local(input int k);
        for (int i = 0; i < CB; i++) begin
            loc_cell[i] = 8'((8'hA0 ^ i) + k);
            push_exp(loc_cell[i], 1'b1, (i == 0));
        end
        loc_req = 1'b1;
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0 || phy_q.size() != 0 || nib_valid);
        repeat (6) @(negedge clk);
    endtask

    // PHY model: present a byte for each strobe edge while enabled.
    int  run_bytes = 0;
    bit  prev_rd = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_stb && utp_rd_en) begin
                if (phy_q.size() != 0) begin
                    logic [8:0] it;
                    it = phy_q.pop_front();
                    utp_data = it[7:0];
                    utp_soc  = it[8];
                end else begin
                    utp_data = '0;
                    utp_soc  = 1'b0;
                    chk(1'b0, "R3 pull with no cell offered", 1, 0);
                end
                run_bytes++;
            end
            if (prev_rd && !utp_rd_en) begin
                int e;
                e = (run_q.size() != 0) ? run_q.pop_front() : -1;
                chk(run_bytes == e, "R3 bytes per pull run", run_bytes, e);
                run_bytes = 0;
            end
            prev_rd  = utp_rd_en;
            utp_clav = (phy_q.size() != 0);
        end
    end

    // Local source: drop the request once granted; count grant length.
    int gnt_cyc = 0;
    bit prev_gnt = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (loc_gnt) begin
                loc_req = 1'b0;
                gnt_cyc++;
            end else if (prev_gnt) begin
                chk(gnt_cyc == NIBS, "R9 grant length", gnt_cyc, NIBS);
                gnt_cyc = 0;
            end
            prev_gnt = loc_gnt;
        end
    end

    // Monitor: pop the scoreboard for every valid nibble.
    int run_len = 0;
    bit prev_val = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (nib_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected nibble", nib_data, 0);
                end else begin
                    logic [5:0] e;
                    e = exp_q.pop_front();
                    chk(nib_data == e[3:0], {cur_req, " R5 nibble value"}, nib_data, e[3:0]);
                    chk(nib_soc == e[4], "R6 start strobe", nib_soc, e[4]);
                    if (e[4]) chk(!prev_val, "R11 gap before cell", prev_val, 0);
                    if (e[4] && !e[5]) chk(!utp_rd_en, "R10 pull held while slot full", utp_rd_en, 0);
                    if (e[4] && e[5]) chk(loc_gnt, "R9 grant during local cell", loc_gnt, 1);
                end
                run_len++;
            end else if (prev_val) begin
                chk(run_len == NIBS, "R5 cell length", run_len, NIBS);
                run_len = 0;
            end
            prev_val = nib_valid;
        end
    end

    initial begin
        for (int i = 0; i < CB; i++) loc_cell[i] = '0;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset.
        chk(!nib_valid && !nib_soc, "R1 output idle in reset", {nib_valid, nib_soc}, 0);
        chk(!utp_rd_en && !loc_gnt, "R1 no pull or grant in reset", {utp_rd_en, loc_gnt}, 0);
        chk(!byte_stb, "R1 strobe low in reset", byte_stb, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        // R2: strobe alternates every cycle.
        for (int i = 0; i < 6; i++) begin
            logic p;
            p = byte_stb;
            @(negedge clk);
            chk(byte_stb == !p, "R2 strobe alternates", byte_stb, !p);
        end

        // One UTOPIA cell on its own.
        cur_req = "R7";
        run_q.push_back(CB);
        push_utp(1);
        drain();

        // One local cell on its own.
        cur_req = "R9";
        req_local(1);
        drain();

        // Local request raised while a UTOPIA cell is on offer: UTOPIA first.
        cur_req = "R8";
        run_q.push_back(CB);
        push_utp(2);
        req_local(2);
        drain();

        // Junk before a marked byte 0: realign on the marker.
        cur_req = "R4";
        for (int i = 0; i < 10; i++) phy_q.push_back({1'b0, 8'(8'hE0 + i)});
        run_q.push_back(CB + 10);
        push_utp(3);
        drain();

        // Local cell, then three UTOPIA cells into a single slot.
        cur_req = "R10";
        req_local(3);
        do @(negedge clk); while (!loc_gnt);
        for (int k = 4; k < 7; k++) begin
            run_q.push_back(CB);
            push_utp(k);
        end
        drain();

        chk(exp_q.size() == 0, "R7 all cells delivered", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired, pending nibbles actual=%0d expected=0", exp_q.size());
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule